// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block sits at the input of a display controller. Once the controller is enabled, it decides what the incoming 32-bit word stream carries. The stream can hold a color lookup table, frame pixels, or a lookup table followed by frame pixels. Lookup-table words are split into two 16-bit entries. Each entry is stored as a 12-bit color in an internal 256-entry table, which the pixel path reads through an asynchronous read port.

The first table word holds a depth code in its top nibble. That code sets how many bytes of table follow and therefore how many words are consumed. When the table is complete, the block raises a loaded flag and, if enabled, an interrupt. It then either stalls the stream until the controller is disabled or switches to forwarding pixel words downstream. If the depth code is unsupported, the load is aborted and an error flag is raised.

Top module: `pal_frame_load_seq`

## Requirements
- R1: After reset, and in every cycle while `enable` is low, `s_ready`, `m_valid`, `pal_loaded`, `pal_irq` and `load_err` are all low.
- R2: `load_mode` is sampled in the first enabled cycle. The value 1 means table only, 2 means frames only, 0 means table then frames, and 3 behaves like 0.
- R3: Bits 15:12 of the first table word select the table size. Codes 0, 1 and 2 give 256 bytes (128 entries), code 3 gives 512 bytes (256 entries) and code 4 gives 32 bytes (16 entries). After that word, `bpp_code` shows the accepted code.
- R4: A table load consumes exactly bytes/4 + 1 stream words: 65, 129 or 9.
- R5: Word k writes its bits 15:0 to entry 2k and its bits 31:16 to entry 2k+1. Each entry keeps only bits 11:0, read as red 11:8, green 7:4 and blue 3:0 on `rd_data` for `rd_addr`.
- R6: Halves whose entry index is at or beyond the entry count are dropped, and the table entries at those indices keep their previous contents.
- R7: In table-only mode, `pal_loaded` rises in the cycle after the last table word is accepted, and `s_ready` then stays low until `enable` falls. `pal_loaded` is low while earlier words are accepted.
- R8: In the combined modes, the word after the last table word is handled as frame data.
- R9: During the frame phase, `m_valid` follows `s_valid`, `m_data` follows `s_data` and `s_ready` follows `m_ready` in the same cycle, and the table is not written.
- R10: `pal_irq` is high exactly when `pal_loaded` and `pal_irq_en` are both high.
- R11: `stat_clr` clears `pal_loaded` only in table-only mode. In the other modes, only dropping `enable` clears it.
- R12: A depth code above 4 in the first word sets `load_err`, writes nothing to the table, leaves `pal_loaded` low and holds `s_ready` low until `enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low returns to idle |
| load_mode | input | 2 | Load sequence select |
| pal_irq_en | input | 1 | Interrupt enable for the loaded flag |
| stat_clr | input | 1 | Clear pulse for the loaded flag |
| s_data | input | 32 | Input stream word |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| m_data | output | 32 | Forwarded pixel word |
| m_valid | output | 1 | Forwarded word valid |
| m_ready | input | 1 | Downstream ready |
| rd_addr | input | 8 | Table read index |
| rd_data | output | 12 | Table read color |
| bpp_code | output | 3 | Last accepted depth code |
| pal_loaded | output | 1 | Table load complete flag |
| pal_irq | output | 1 | Interrupt request |
| load_err | output | 1 | Unsupported depth code seen |

## Verification
All five depth codes are loaded in table-only mode. The order is chosen so that the 256-entry load fills the whole table first; the smaller loads that follow must then leave the upper entries and the trailing dropped halves untouched. That separates a correct word count and entry bound from an off-by-one in either. The combined and frame-only runs send distinct pixel words, with and without downstream back-pressure, so that a word routed to the wrong path shows up as a changed table entry or a missing forwarded word. A load with an illegal depth code and a check that `stat_clr` does nothing outside table-only mode cover the abort path and the mode-dependent clear.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        LM_BOTH  = 2'd0,
        LM_PAL   = 2'd1,
        LM_FRAME = 2'd2,
        LM_RSVD  = 2'd3
    } load_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAL,
        ST_FRAME,
        ST_HOLD
    } seq_state_e;

    localparam logic [3:0] MAX_CODE = 4'd4;

    // number of 16-bit table entries implied by a depth code
    function automatic logic [15:0] entries_for_code(input logic [3:0] code);
        case (code)
            4'd3:    return 16'd256;
            4'd4:    return 16'd16;
            default: return 16'd128;
        endcase
    endfunction

    function automatic logic code_supported(input logic [3:0] code);
        return code <= MAX_CODE;
    endfunction

endpackage

// File: rtl/lps_palette_ram.sv
module lps_palette_ram #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 12,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [WIDTH-1:0]  data_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [WIDTH-1:0]  data_b,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= data_a;
        if (we_b) mem[addr_b] <= data_b;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lps_frame_gate.sv
module lps_frame_gate #(
    parameter int DATA_W = 32
) (
    input  logic              active,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    assign out_data  = in_data;
    assign out_valid = active & in_valid;
    assign in_ready  = active & out_ready;
endmodule

// File: rtl/lps_load_ctrl.sv
module lps_load_ctrl
    import lps_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int COLOR_W = 12,
    parameter int DEPTH   = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH / 2 + 2),
    localparam int IDX_W  = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [1:0]         load_mode,
    input  logic               stat_clr,
    input  logic [DATA_W-1:0]  s_data,
    input  logic               s_valid,
    output logic               pal_ready,
    output logic               frame_active,
    output logic               we_a,
    output logic [ADDR_W-1:0]  addr_a,
    output logic [COLOR_W-1:0] data_a,
    output logic               we_b,
    output logic [ADDR_W-1:0]  addr_b,
    output logic [COLOR_W-1:0] data_b,
    output logic [2:0]         bpp_code,
    output logic               pal_loaded,
    output logic               load_err
);
    seq_state_e       state_q;
    load_mode_e       mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       code_q;
    logic             loaded_q, err_q;

    logic [3:0]       code_in;
    logic             code_ok, pal_acc, last_word;
    logic [15:0]      n_ent;
    logic [IDX_W-1:0] idx_lo, idx_hi;

    assign code_in   = (cnt_q == '0) ? s_data[15:12] : code_q;
    assign code_ok   = code_supported(code_in);
    assign n_ent     = entries_for_code(code_in);
    assign pal_ready = enable && (state_q == ST_PAL);
    assign pal_acc   = pal_ready && s_valid;
    assign last_word = pal_acc && code_ok && (16'(cnt_q) == (n_ent >> 1));

    assign idx_lo = {cnt_q, 1'b0};
    assign idx_hi = {cnt_q, 1'b1};

    assign we_a   = pal_acc && code_ok && (16'(idx_lo) < n_ent) && (int'(idx_lo) < DEPTH);
    assign we_b   = pal_acc && code_ok && (16'(idx_hi) < n_ent) && (int'(idx_hi) < DEPTH);
    assign addr_a = idx_lo[ADDR_W-1:0];
    assign addr_b = idx_hi[ADDR_W-1:0];
    assign data_a = s_data[COLOR_W-1:0];
    assign data_b = s_data[16 +: COLOR_W];

    assign frame_active = enable && (state_q == ST_FRAME);
    assign pal_loaded   = loaded_q;
    assign load_err     = err_q;
    assign bpp_code     = code_q[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= LM_BOTH;
            cnt_q    <= '0;
            code_q   <= '0;
            loaded_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (!enable) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            loaded_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (stat_clr && mode_q == LM_PAL)
                loaded_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    mode_q  <= load_mode_e'(load_mode);
                    cnt_q   <= '0;
                    state_q <= (load_mode_e'(load_mode) == LM_FRAME) ? ST_FRAME : ST_PAL;
                end
                ST_PAL: begin
                    if (pal_acc) begin
                        if (!code_ok) begin
                            err_q   <= 1'b1;
                            state_q <= ST_HOLD;
                        end else begin
                            if (cnt_q == '0)
                                code_q <= code_in;
                            if (last_word) begin
                                loaded_q <= 1'b1;
                                state_q  <= (mode_q == LM_PAL) ? ST_HOLD : ST_FRAME;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pal_frame_load_seq.sv
module pal_frame_load_seq #(
    parameter int DATA_W  = 32,
    parameter int COLOR_W = 12,
    parameter int DEPTH   = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [1:0]         load_mode,
    input  logic               pal_irq_en,
    input  logic               stat_clr,
    input  logic [DATA_W-1:0]  s_data,
    input  logic               s_valid,
    output logic               s_ready,
    output logic [DATA_W-1:0]  m_data,
    output logic               m_valid,
    input  logic               m_ready,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [COLOR_W-1:0] rd_data,
    output logic [2:0]         bpp_code,
    output logic               pal_loaded,
    output logic               pal_irq,
    output logic               load_err
);
    logic               pal_ready, frame_active, frame_ready;
    logic               we_a, we_b;
    logic [ADDR_W-1:0]  addr_a, addr_b;
    logic [COLOR_W-1:0] data_a, data_b;

    lps_load_ctrl #(.DATA_W(DATA_W), .COLOR_W(COLOR_W), .DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .enable(enable), .load_mode(load_mode),
        .stat_clr(stat_clr), .s_data(s_data), .s_valid(s_valid),
        .pal_ready(pal_ready), .frame_active(frame_active),
        .we_a(we_a), .addr_a(addr_a), .data_a(data_a),
        .we_b(we_b), .addr_b(addr_b), .data_b(data_b),
        .bpp_code(bpp_code), .pal_loaded(pal_loaded), .load_err(load_err)
    );

    lps_palette_ram #(.DEPTH(DEPTH), .WIDTH(COLOR_W)) ram_i (
        .clk(clk), .we_a(we_a), .addr_a(addr_a), .data_a(data_a),
        .we_b(we_b), .addr_b(addr_b), .data_b(data_b),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    lps_frame_gate #(.DATA_W(DATA_W)) gate_i (
        .active(frame_active), .in_data(s_data), .in_valid(s_valid),
        .in_ready(frame_ready), .out_data(m_data), .out_valid(m_valid),
        .out_ready(m_ready)
    );

    assign s_ready = pal_ready | frame_ready;
    assign pal_irq = pal_loaded & pal_irq_en;
endmodule

// File: rtl/lps_chk.sv
module lps_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic s_ready,
    input logic m_valid,
    input logic m_ready,
    input logic pal_loaded,
    input logic pal_irq,
    input logic pal_irq_en,
    input logic load_err
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pal_loaded && !load_err));

    // R1
    disabled_noready_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!s_ready && !m_valid));

    // R12
    err_stall_chk: assert property (@(posedge clk) disable iff (rst)
        load_err |-> (!s_ready && !pal_loaded));

    // R9
    frame_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (s_ready == m_ready));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pal_irq) |-> (pal_irq_en && pal_loaded));
endmodule

bind pal_frame_load_seq lps_chk chk_i (
    .clk(clk), .rst(rst), .enable(enable), .s_ready(s_ready),
    .m_valid(m_valid), .m_ready(m_ready), .pal_loaded(pal_loaded),
    .pal_irq(pal_irq), .pal_irq_en(pal_irq_en), .load_err(load_err)
);

// File: tb/pal_frame_load_seq_tb.sv
module pal_frame_load_seq_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 0, rst = 1, enable = 0, pal_irq_en = 0, stat_clr = 0;
    logic [1:0]  load_mode = 0;
    logic [31:0] s_data = 0, m_data;
    logic        s_valid = 0, s_ready, m_valid, m_ready = 1;
    logic [7:0]  rd_addr = 0;
    logic [11:0] rd_data;
    logic [2:0]  bpp_code;
    logic        pal_loaded, pal_irq, load_err;

    int n_cmp = 0, n_bad = 0;
    logic [11:0] exp_tbl [256];

    always #(CLK_P/2) clk = ~clk;

    pal_frame_load_seq dut_i (
        .clk(clk), .rst(rst), .enable(enable), .load_mode(load_mode),
        .pal_irq_en(pal_irq_en), .stat_clr(stat_clr), .s_data(s_data),
        .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data),
        .m_valid(m_valid), .m_ready(m_ready), .rd_addr(rd_addr),
        .rd_data(rd_data), .bpp_code(bpp_code), .pal_loaded(pal_loaded),
        .pal_irq(pal_irq), .load_err(load_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ent_count(input int code);
        return (code == 3) ? 256 : (code == 4) ? 16 : 128;
    endfunction

    function automatic logic [11:0] ent_val(input int seed, input int i);
        return 12'((i * 37 + seed * 101 + 3) & 12'hFFF);
    endfunction

    function automatic logic [31:0] word_of(input int code, input int seed, input int k);
        logic [3:0] top;
        top = (k == 0) ? 4'(code) : 4'h5;
        return {4'hA, ent_val(seed, 2*k+1), top, ent_val(seed, 2*k)};
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        s_valid = 1; s_data = w;
        for (int t = 0; t < 50; t++) begin
            #1;
            if (s_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 s_valid = 0;
    endtask

    task automatic start(input logic [1:0] m);
        @(negedge clk); load_mode = m; enable = 1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk); enable = 0;
        @(negedge clk); #1;
        check("R1 loaded cleared by disable", {31'b0, pal_loaded}, 32'd0);
        check("R1 ready low when disabled", {31'b0, s_ready}, 32'd0);
    endtask

    task automatic load_table(input int code, input int seed);
        int n = ent_count(code);
        int words = n / 2 + 1;
        for (int k = 0; k < words; k++) begin
            if (k == words - 1) begin
                @(negedge clk); #1;
                check("R7 loaded low before last word", {31'b0, pal_loaded}, 32'd0);
            end
            push(word_of(code, seed, k));
        end
        for (int i = 0; i < n; i++) exp_tbl[i] = ent_val(seed, i);
    endtask

    task automatic check_table(input string req);
        for (int i = 0; i < 256; i++) begin
            rd_addr = 8'(i); #1;
            check(req, {20'b0, rd_data}, {20'b0, exp_tbl[i]});
        end
    endtask

    task automatic frame_word(input logic [31:0] w);
        @(negedge clk); s_valid = 1; s_data = w; m_ready = 1; #1;
        check("R9 m_valid follows s_valid", {31'b0, m_valid}, 32'd1);
        check("R9 m_data follows s_data", m_data, w);
        check("R9 s_ready follows m_ready", {31'b0, s_ready}, 32'd1);
        m_ready = 0; #1;
        check("R9 back-pressure", {31'b0, s_ready}, 32'd0);
        m_ready = 1;
        @(posedge clk); #1 s_valid = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        check("R1 reset s_ready", {31'b0, s_ready}, 32'd0);
        check("R1 reset m_valid", {31'b0, m_valid}, 32'd0);
        check("R1 reset pal_loaded", {31'b0, pal_loaded}, 32'd0);
        check("R1 reset load_err", {31'b0, load_err}, 32'd0);
        check("R10 reset pal_irq", {31'b0, pal_irq}, 32'd0);

        // table-only loads in an order that exposes dropped halves (R4 R6)
        for (int j = 0; j < 5; j++) begin
            int code = (j == 0) ? 3 : (j == 1) ? 4 : j - 2;
            start(2'd1);
            #1 check("R2 table-only accepts words", {31'b0, s_ready}, 32'd1);
            load_table(code, j + 1);
            @(negedge clk); #1;
            check("R7 loaded after last word", {31'b0, pal_loaded}, 32'd1);
            check("R4 R7 stream stalled after table", {31'b0, s_ready}, 32'd0);
            check("R3 bpp_code", {29'b0, bpp_code}, 32'(code));
            check("R10 irq masked", {31'b0, pal_irq}, 32'd0);
            pal_irq_en = 1; #1;
            check("R10 irq enabled", {31'b0, pal_irq}, 32'd1);
            check_table("R5 R6 table contents");
            @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0; #1;
            check("R11 clear in table-only mode", {31'b0, pal_loaded}, 32'd0);
            check("R10 irq follows flag", {31'b0, pal_irq}, 32'd0);
            pal_irq_en = 0;
            stop();
        end

        // combined mode 0 and mode 3 (R8 R11)
        for (int m = 0; m < 4; m += 3) begin
            start(2'(m));
            load_table(4, 10 + m);
            @(negedge clk); #1;
            check("R8 loaded in combined mode", {31'b0, pal_loaded}, 32'd1);
            frame_word(32'hC0DE_0000 + 32'(m));
            frame_word(32'h1234_5678);
            @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0; #1;
            check("R11 clear ignored outside table-only", {31'b0, pal_loaded}, 32'd1);
            check_table("R8 R9 frames leave table intact");
            stop();
        end

        // frame-only mode (R2 R9)
        start(2'd2);
        frame_word(32'h3FFF_0000);
        frame_word(32'h0000_4FFF);
        @(negedge clk); #1;
        check("R2 frame-only sets no flag", {31'b0, pal_loaded}, 32'd0);
        check_table("R9 frame-only leaves table intact");
        stop();

        // unsupported code (R12)
        start(2'd1);
        push({4'hA, 12'h111, 4'd7, 12'h222});
        @(negedge clk); #1;
        check("R12 error flag", {31'b0, load_err}, 32'd1);
        check("R12 stream stalled", {31'b0, s_ready}, 32'd0);
        check("R12 no loaded flag", {31'b0, pal_loaded}, 32'd0);
        check_table("R12 no table write");
        stop();
        check("R1 error cleared by disable", {31'b0, load_err}, 32'd0);

        finish_run();
    end
endmodule